// File: doc/BRIEF.md
# Parallel Slave Data Port

This block sits between a local processor and an external 8-bit bus master that shares one bidirectional data bus. When the port runs in plain mode, its data register works as an ordinary general-purpose port: a direction register chooses, bit by bit, whether the port drives the pins or samples them.

When slave mode is on, the external master reads and writes the data register through three active-low strobes. These are a read strobe, a write strobe and a chip select. The block holds a separate output latch and input latch. It keeps status flags for output-full, input-full and input-overrun. At the end of every completed external access it raises an interrupt flag, and that flag can raise an interrupt request.

The external strobes are asynchronous. The block passes them through a two-stage synchroniser. All flag updates happen in the local clock domain on the trailing edge of an access, which means the cycle in which the combined select-and-strobe condition goes inactive. The bus output enable is taken directly from the raw strobes, so read data reaches the bus without synchroniser delay.

Top module: `pbus_slave`

Local register map (`cpuAddr`): 0 = data, 1 = control/status, 2 = direction, 3 = interrupt. Writes take effect on the clock edge where `cpuSel` and `cpuWe` are both high. Reads on `cpuRdata` are combinational. Strobe-driven flags change on the third clock edge after the raw strobe changes.

## Requirements
- R1: After reset, control/status reads 0x00, direction reads 0xFF, interrupt reads 0x00, `busOe` is 0 and `irq` is 0.
- R2: In plain mode (control bit 4 = 0), `busOut` shows the last value written to the data register, and `busOe` is the inverse of the direction register (direction bit 1 means input). A data read returns `busIn` on the input bits and the written value on the output bits.
- R3: In slave mode (control bit 4 = 1), a local data write does not enable the bus drivers. The same write sets output-full, which is control bit 6.
- R4: In slave mode, while read strobe and chip select are both low, `busOe` is all ones and `busOut` is the output latch. Output-full clears once that access is seen in the clock domain.
- R5: The interrupt flag (interrupt register bit 0) stays clear while a read access is active. It is set when the read strobe is released.
- R6: During a write access, input-full (control bit 7) stays clear. When write strobe or chip select is released, the bus value is captured and input-full is set.
- R7: In slave mode, a data read returns the input latch and clears input-full.
- R8: A write access that completes while input-full is set raises input-overrun (control bit 5) and leaves the input latch unchanged.
- R9: Any write to control clears input-overrun and leaves input-full unchanged. A control write with bit 4 = 0 returns to plain mode and clears input-full. Control bits 2:0 are stored and read back.
- R10: `irq` equals interrupt flag AND interrupt enable (interrupt register bit 1). Writing bit 0 = 0 clears the flag.
- R11: With chip select high, the read and write strobes change no flag and do not enable the bus drivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuSel | input | 1 | Local register access valid |
| cpuWe | input | 1 | Local access is a write |
| cpuAddr | input | 2 | Local register select |
| cpuWdata | input | 8 | Local write data |
| cpuRdata | output | 8 | Local read data (combinational) |
| busIn | input | 8 | Sampled value of the shared bus |
| busOut | output | 8 | Value this block drives onto the bus |
| busOe | output | 8 | Per-bit bus drive enable |
| rdN | input | 1 | External read strobe, active low |
| wrN | input | 1 | External write strobe, active low |
| csN | input | 1 | External chip select, active low |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is input-overrun while the input latch still holds older unread data. It needs two external writes to complete back to back with no local read between them, and the bus value has to change between the two writes so that a discarded capture can be told apart from a kept one. The stimulus holds the write strobe low and toggles chip select, which ends each write, with a different bus value on each toggle. It then reads the latch, clears overrun with a control write while input-full is set again, and drops slave mode. A behavioural model that replays the synchroniser delay with a history queue is compared against `busOe`, `busOut`, `irq` and `cpuRdata` on every cycle.

// File: rtl/pbus_pkg.sv
`timescale 1ns/1ps
package pbus_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_INT  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOut;    // local data write
    logic loadDir;    // local direction write
    logic holdBus;    // external write active: track bus
    logic captureIn;  // write ended with room: move held value to input latch
  } pbusStrobe_t;
endpackage

// File: rtl/pbus_sync.sv
`timescale 1ns/1ps
module pbus_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pbus_ctrl.sv
`timescale 1ns/1ps
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              wdMode,
  input  logic [2:0]        wdLow,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              csN,
  output pbusStrobe_t       strb,
  output logic              pspMode,
  output logic [7:0]        statusByte,
  output logic [7:0]        intByte,
  output logic              irq
);
  logic [2:0] strbSync;
  logic ibf, obf, ibov, flag, intEn;
  logic [2:0] dirBits;
  logic prevRd, prevWr;
  logic rdAct, wrAct, rdEnd, wrEnd;
  logic wrData, rdData, wrCtrl, wrDir, wrInt;

  pbus_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din({rdN, wrN, csN}), .dout(strbSync)
  );

  assign rdAct = pspMode && !strbSync[2] && !strbSync[0];
  assign wrAct = pspMode && !strbSync[1] && !strbSync[0];
  assign rdEnd = pspMode && prevRd && !rdAct;
  assign wrEnd = pspMode && prevWr && !wrAct;

  assign wrData = cpuSel && cpuWe && (cpuAddr == ADDR_DATA);
  assign rdData = cpuSel && !cpuWe && (cpuAddr == ADDR_DATA);
  assign wrCtrl = cpuSel && cpuWe && (cpuAddr == ADDR_CTRL);
  assign wrDir  = cpuSel && cpuWe && (cpuAddr == ADDR_DIR);
  assign wrInt  = cpuSel && cpuWe && (cpuAddr == ADDR_INT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRd  <= 1'b0;
      prevWr  <= 1'b0;
      ibf     <= 1'b0;
      obf     <= 1'b0;
      ibov    <= 1'b0;
      pspMode <= 1'b0;
      dirBits <= '0;
      flag    <= 1'b0;
      intEn   <= 1'b0;
    end else begin
      prevRd <= rdAct;
      prevWr <= wrAct;
      if (wrEnd && !ibf) ibf <= 1'b1;
      else if ((rdData && pspMode) || (wrCtrl && !wdMode)) ibf <= 1'b0;
      if (wrCtrl) ibov <= 1'b0;
      else if (wrEnd && ibf) ibov <= 1'b1;
      if (wrData && pspMode) obf <= 1'b1;
      else if (rdAct) obf <= 1'b0;
      if (rdEnd || wrEnd) flag <= 1'b1;
      else if (wrInt) flag <= wdLow[0];
      if (wrInt) intEn <= wdLow[1];
      if (wrCtrl) begin
        pspMode <= wdMode;
        dirBits <= wdLow;
      end
    end
  end

  always_comb begin
    strb.loadOut   = wrData;
    strb.loadDir   = wrDir;
    strb.holdBus   = wrAct;
    strb.captureIn = wrEnd && !ibf;
  end

  assign statusByte = {ibf, obf, ibov, pspMode, 1'b0, dirBits};
  assign intByte    = {6'b0, intEn, flag};
  assign irq        = flag && intEn;
endmodule

// File: rtl/pbus_datapath.sv
`timescale 1ns/1ps
module pbus_datapath
  import pbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pbusStrobe_t       strb,
  input  logic              pspMode,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [7:0]        statusByte,
  input  logic [7:0]        intByte,
  input  logic [DATA_W-1:0] busIn,
  input  logic              rdN,
  input  logic              csN,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] busOut,
  output logic [DATA_W-1:0] busOe
);
  logic [DATA_W-1:0] outLatch, inLatch, dirReg, busHold, dataView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= '0;
      inLatch  <= '0;
      dirReg   <= '1;
      busHold  <= '0;
    end else begin
      if (strb.loadOut)   outLatch <= cpuWdata;
      if (strb.loadDir)   dirReg   <= cpuWdata;
      if (strb.holdBus)   busHold  <= busIn;
      if (strb.captureIn) inLatch  <= busHold;
    end
  end

  assign busOut   = outLatch;
  assign busOe    = pspMode ? {DATA_W{!rdN && !csN}} : ~dirReg;
  assign dataView = pspMode ? inLatch : ((busIn & dirReg) | (outLatch & ~dirReg));

  always_comb begin
    case (cpuAddr)
      ADDR_DATA: cpuRdata = dataView;
      ADDR_CTRL: cpuRdata = DATA_W'(statusByte);
      ADDR_DIR:  cpuRdata = dirReg;
      default:   cpuRdata = DATA_W'(intByte);
    endcase
  end
endmodule

// File: rtl/pbus_slave.sv
`timescale 1ns/1ps
module pbus_slave
  import pbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic [DATA_W-1:0] busOe,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              csN,
  output logic              irq
);
  pbusStrobe_t strb;
  logic pspMode;
  logic [7:0] statusByte, intByte;

  pbus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .wdMode(cpuWdata[4]), .wdLow(cpuWdata[2:0]),
    .rdN(rdN), .wrN(wrN), .csN(csN),
    .strb(strb), .pspMode(pspMode), .statusByte(statusByte), .intByte(intByte), .irq(irq)
  );

  pbus_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pspMode(pspMode), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .statusByte(statusByte), .intByte(intByte), .busIn(busIn),
    .rdN(rdN), .csN(csN), .cpuRdata(cpuRdata), .busOut(busOut), .busOe(busOe)
  );
endmodule

// File: rtl/pbus_slave_chk.sv
`timescale 1ns/1ps
module pbus_slave_chk
  import pbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuSel,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              obf,
  input logic              ibf,
  input logic              ibov,
  input logic              flag,
  input logic              rdAct,
  input logic              wrAct,
  input logic [DATA_W-1:0] inLatch
);
  logic intWr, ctrlWr;
  assign intWr  = cpuSel && cpuWe && (cpuAddr == ADDR_INT);
  assign ctrlWr = cpuSel && cpuWe && (cpuAddr == ADDR_CTRL);

  // R4
  obf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(obf) |-> $past(rdAct));

  // R5
  flag_trailing_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flag) && !$past(intWr)) |-> (!$past(rdAct) && !$past(wrAct)));

  // R6
  ibf_trailing_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ibf) |-> !$past(wrAct));

  // R8
  latch_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ibf && $past(ibf)) |-> $stable(inLatch));

  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> !ibov);
endmodule

bind pbus_slave pbus_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
  .obf(u_ctrl.obf), .ibf(u_ctrl.ibf), .ibov(u_ctrl.ibov), .flag(u_ctrl.flag),
  .rdAct(u_ctrl.rdAct), .wrAct(u_ctrl.wrAct), .inLatch(u_dp.inLatch)
);

// File: tb/pbus_slave_bench.sv
`timescale 1ns/1ps
module pbus_slave_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuSel = 1'b0, cpuWe = 1'b0;
  logic [1:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0, busIn = '0;
  logic rdN = 1'b1, wrN = 1'b1, csN = 1'b1;
  logic [7:0] cpuRdata, busOut, busOe;
  logic irq;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  pbus_slave u_pbus_slave (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .rdN(rdN), .wrN(wrN), .csN(csN), .irq(irq)
  );

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0] strobeHist[$];
  logic mIbf, mObf, mIbov, mMode, mIf, mIe, mPrevR, mPrevW;
  logic [2:0] mDirB;
  logic [7:0] mOut, mIn, mDdr, mHold;
  logic [2:0] oldS;
  logic rA, wA, rE, wE, oIbf, wrD, rdD, wrC, wrR, wrI;

  always @(posedge clk) begin
    if (!rstN) begin
      strobeHist = {3'b111, 3'b111};
      {mIbf, mObf, mIbov, mMode, mIf, mIe, mPrevR, mPrevW} = '0;
      mDirB = '0; mOut = '0; mIn = '0; mDdr = 8'hFF; mHold = '0;
    end else begin
      oldS = strobeHist[0];
      void'(strobeHist.pop_front());
      strobeHist.push_back({rdN, wrN, csN});
      rA = mMode && !oldS[2] && !oldS[0];
      wA = mMode && !oldS[1] && !oldS[0];
      rE = mMode && mPrevR && !rA;
      wE = mMode && mPrevW && !wA;
      wrD = cpuSel && cpuWe && cpuAddr == 2'd0;
      rdD = cpuSel && !cpuWe && cpuAddr == 2'd0;
      wrC = cpuSel && cpuWe && cpuAddr == 2'd1;
      wrR = cpuSel && cpuWe && cpuAddr == 2'd2;
      wrI = cpuSel && cpuWe && cpuAddr == 2'd3;
      oIbf = mIbf;
      if (wE && !oIbf) begin mIbf = 1'b1; mIn = mHold; end
      else if ((rdD && mMode) || (wrC && !cpuWdata[4])) mIbf = 1'b0;
      if (wrC) mIbov = 1'b0; else if (wE && oIbf) mIbov = 1'b1;
      if (wrD && mMode) mObf = 1'b1; else if (rA) mObf = 1'b0;
      if (rE || wE) mIf = 1'b1; else if (wrI) mIf = cpuWdata[0];
      if (wrI) mIe = cpuWdata[1];
      if (wrD) mOut = cpuWdata;
      if (wrR) mDdr = cpuWdata;
      if (wA) mHold = busIn;
      if (wrC) begin mMode = cpuWdata[4]; mDirB = cpuWdata[2:0]; end
      mPrevR = rA; mPrevW = wA;
    end
  end

  function automatic logic [7:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return mMode ? mIn : ((busIn & mDdr) | (mOut & ~mDdr));
      2'd1: return {mIbf, mObf, mIbov, mMode, 1'b0, mDirB};
      2'd2: return mDdr;
      default: return {6'b0, mIe, mIf};
    endcase
  endfunction

  always @(negedge clk) begin
    #1;
    if (rstN) begin
      logic [7:0] expOe;
      expOe = mMode ? {8{!rdN && !csN}} : ~mDdr;
      check(busOe === expOe, "model R4 busOe", busOe, expOe);
      check(busOut === mOut, "model R2 busOut", busOut, mOut);
      check(irq === (mIf && mIe), "model R10 irq", {7'b0, irq}, {7'b0, mIf && mIe});
      check(cpuRdata === modelRead(cpuAddr), "model R7 cpuRdata", cpuRdata, modelRead(cpuAddr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cpuWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cpuSel = 1'b1; cpuWe = 1'b1; cpuAddr = a; cpuWdata = d;
    @(negedge clk); cpuSel = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic expectRead(input logic [1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    @(negedge clk); cpuSel = 1'b1; cpuWe = 1'b0; cpuAddr = a;
    #1 v = cpuRdata;
    check(v === exp, tag, v, exp);
    @(negedge clk); cpuSel = 1'b0;
  endtask

  task automatic strobes(input logic r, input logic w, input logic c);
    @(negedge clk); rdN = r; wrN = w; csN = c;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #500000;
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    #1 check(busOe === 8'h00, "R1 busOe", busOe, 8'h00);
    check(irq === 1'b0, "R1 irq", {7'b0, irq}, 8'h00);
    expectRead(2'd1, 8'h00, "R1 status");
    expectRead(2'd2, 8'hFF, "R1 direction");
    expectRead(2'd3, 8'h00, "R1 interrupt");

    // R2 plain port
    cpuWrite(2'd2, 8'h00);
    cpuWrite(2'd0, 8'h55);
    #1 check(busOe === 8'hFF, "R2 busOe all out", busOe, 8'hFF);
    check(busOut === 8'h55, "R2 busOut", busOut, 8'h55);
    cpuWrite(2'd2, 8'hF0);
    busIn = 8'hA3;
    #1 check(busOe === 8'h0F, "R2 busOe mixed", busOe, 8'h0F);
    expectRead(2'd0, 8'hA5, "R2 mixed read");
    cpuWrite(2'd2, 8'hFF);

    // R3 slave mode local write
    cpuWrite(2'd1, 8'h17);
    expectRead(2'd1, 8'h17, "R9 control readback");
    cpuWrite(2'd0, 8'hF0);
    #1 check(busOe === 8'h00, "R3 no drive", busOe, 8'h00);
    expectRead(2'd1, 8'h57, "R3 output-full set");

    // R4/R5 external read
    strobes(1'b0, 1'b1, 1'b0);
    #1 check(busOe === 8'hFF, "R4 drive on read", busOe, 8'hFF);
    check(busOut === 8'hF0, "R4 latch on bus", busOut, 8'hF0);
    idle(4);
    expectRead(2'd1, 8'h17, "R4 output-full cleared");
    expectRead(2'd3, 8'h00, "R5 no flag during read");
    strobes(1'b1, 1'b1, 1'b0);
    idle(4);
    expectRead(2'd3, 8'h01, "R5 flag after read");
    check(irq === 1'b0, "R10 masked", {7'b0, irq}, 8'h00);

    // R6/R7 external write
    cpuWrite(2'd3, 8'h00);
    busIn = 8'h0F;
    strobes(1'b1, 1'b0, 1'b0);
    idle(4);
    expectRead(2'd1, 8'h17, "R6 input-full clear during write");
    strobes(1'b1, 1'b0, 1'b1);
    idle(4);
    expectRead(2'd1, 8'h97, "R6 input-full set");
    expectRead(2'd3, 8'h01, "R6 flag after write");
    expectRead(2'd0, 8'h0F, "R7 input latch");
    expectRead(2'd1, 8'h17, "R7 input-full cleared");

    // R8 overrun
    strobes(1'b1, 1'b0, 1'b0); idle(4); strobes(1'b1, 1'b0, 1'b1); idle(4);
    busIn = 8'h3C;
    strobes(1'b1, 1'b0, 1'b0); idle(4); strobes(1'b1, 1'b0, 1'b1); idle(4);
    expectRead(2'd1, 8'hB7, "R8 overrun set");
    expectRead(2'd0, 8'h0F, "R8 latch kept");
    expectRead(2'd1, 8'h37, "R8 overrun stays after read");
    strobes(1'b1, 1'b0, 1'b0); idle(4); strobes(1'b1, 1'b0, 1'b1); idle(4);
    expectRead(2'd1, 8'hB7, "R8 full again");

    // R9 control writes
    cpuWrite(2'd1, 8'h17);
    expectRead(2'd1, 8'h97, "R9 overrun cleared, full kept");
    cpuWrite(2'd1, 8'h07);
    expectRead(2'd1, 8'h07, "R9 plain mode clears full");
    expectRead(2'd0, 8'h3C, "R2 pins after mode off");

    // R11 strobes without chip select
    cpuWrite(2'd1, 8'h17);
    cpuWrite(2'd3, 8'h00);
    strobes(1'b1, 1'b1, 1'b1); idle(4);
    strobes(1'b1, 1'b0, 1'b1); idle(4);
    strobes(1'b1, 1'b1, 1'b1); idle(4);
    expectRead(2'd1, 8'h17, "R11 no input-full");
    expectRead(2'd3, 8'h00, "R11 no flag");
    strobes(1'b0, 1'b1, 1'b1);
    #1 check(busOe === 8'h00, "R11 no drive", busOe, 8'h00);
    idle(4);
    strobes(1'b1, 1'b1, 1'b1); idle(4);
    expectRead(2'd3, 8'h00, "R11 no flag after read strobe");

    // R10 interrupt request
    cpuWrite(2'd3, 8'h02);
    #1 check(irq === 1'b0, "R10 enabled idle", {7'b0, irq}, 8'h00);
    strobes(1'b1, 1'b0, 1'b0); idle(4); strobes(1'b1, 1'b0, 1'b1); idle(4);
    #1 check(irq === 1'b1, "R10 irq raised", {7'b0, irq}, 8'h01);
    expectRead(2'd3, 8'h03, "R10 flag and enable");
    cpuWrite(2'd3, 8'h02);
    #1 check(irq === 1'b0, "R10 flag cleared", {7'b0, irq}, 8'h00);
    strobes(1'b1, 1'b1, 1'b1);
    idle(3);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule